// File: doc/BRIEF.md
# Serial Clock-Synthesizer Programming Sequencer

This block loads a new setting into an external clock synthesizer that is programmed one bit at a time over a two-wire data/clock pair. A single start pulse supplies three values: the location address to program, the 13-bit programming word, and the control nibble that is restored afterwards. The block then runs the whole load sequence with no further input.

The sequence has fixed parts. The display is blanked first and a long quiet period follows. Two preamble writes then go out, then a three-bit header that selects a write, then the address and the word, each least significant bit first. Every bit takes two writes: one with the clock line low and one with it high. Each write holds the control nibble steady for a programmable wait and then pulses the strobe line for one cycle. When the frame ends, the block waits, unblanks the display, restores the saved control nibble, waits a long settle period, writes the low four address bits as the final selection, and then pulses done.

Every wait is a cycle count set by a parameter, so the same block serves any system clock.

Top module: `clkprog_seq`

## Requirements
- R1: After reset, ctl_o is 0 and strobe_o, blank_o and done_o are all low.
- R2: A start_i pulse seen while idle captures addr_i, word_i and keep_i. From the next cycle, blank_o is high and ctl_o is 0 for BLANK_DLY cycles, with no strobe.
- R3: The first two strobe writes of a frame carry ctl_o = 0 and then ctl_o = 1.
- R4: In each strobe write, ctl_o takes its new value in the first cycle and holds it. strobe_o is high only in cycle STROBE_DLY+1 of the write, so strobe_o is never high in two cycles in a row during the frame.
- R5: The serial bits go out in this order: the header 1, 0, 0, then the ADDR_W address bits LSB first, then the WORD_W word bits LSB first. Each bit takes two writes. The first has ctl_o = {0, d, 0, 1} and the second has ctl_o = {1, d, 0, 1}, where ctl_o[3] is the serial clock, ctl_o[2] is the data bit d, and ctl_o[1:0] = 01.
- R6: POST_DLY cycles after the last bit write, blank_o falls. In that same cycle ctl_o equals the captured keep value and strobe_o is high.
- R7: SETTLE_DLY cycles after the restore write, ctl_o shows the captured address bits [3:0] with strobe_o high for one cycle. ctl_o keeps that value while idle.
- R8: done_o is high for exactly one cycle: the cycle after the final write.
- R9: A start_i pulse that arrives while a sequence is running has no effect on that sequence.
- R10: blank_o is high from the cycle after the start until the restore write, and low at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a load sequence (used only when idle) |
| addr_i | input | ADDR_W | Location address to program |
| word_i | input | WORD_W | Programming word |
| keep_i | input | 4 | Control nibble restored after the frame |
| ctl_o | output | 4 | Control nibble: [3] serial clock, [2] serial data |
| strobe_o | output | 1 | One-cycle strobe that latches ctl_o |
| blank_o | output | 1 | Display blanking request |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that every delay parameter is at least one cycle. Only with that assumption is a strobe always preceded by a cycle of the same write and never followed by another strobe. The blanking check assumes that blank_o rises only in response to a start pulse. The bench keeps to these assumptions: it uses small delays that are all non-zero, and it drives start_i only at negative edges, either while the block is idle or, on purpose, in the middle of a frame to test R9.

// File: rtl/clkprog_pkg.sv
package clkprog_pkg;
   localparam int CTL_W = 4;
   localparam int HDR_W = 3;
   // header sent LSB first: 1, 0, 0 (last zero selects a write)
   localparam logic [HDR_W-1:0] HDR_BITS = 3'b001;
   localparam logic [1:0] CTL_LOW_BITS = 2'b01;

   typedef enum logic [2:0] {
      PS_IDLE, PS_BLANK, PS_STEP, PS_POST,
      PS_RESTORE, PS_SETTLE, PS_FINAL, PS_DONE
   } ps_state_t;
endpackage

// File: rtl/clkprog_timer.sv
module clkprog_timer #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic [CW-1:0] limit,
   output logic          hit
);
   logic [CW-1:0] cnt_q;

   assign hit = run && (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (!run || hit) cnt_q <= '0;
      else                 cnt_q <= cnt_q + 1'b1;
   end

   // R4
   timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> cnt_q <= limit);
endmodule

// File: rtl/clkprog_ctlmux.sv
module clkprog_ctlmux
   import clkprog_pkg::*;
#(
   parameter int FW = 21,
   parameter int SW = 6
) (
   input  ps_state_t        state,
   input  logic [SW-1:0]    step,
   input  logic [FW-1:0]    frame,
   input  logic [CTL_W-1:0] keep,
   input  logic [CTL_W-1:0] sel,
   input  logic [CTL_W-1:0] hold,
   output logic [CTL_W-1:0] ctl
);
   logic [SW-1:0] idx;
   logic          dbit;

   assign idx = (step - SW'(2)) >> 1;

   always_comb begin
      dbit = 1'b0;
      for (int j = 0; j < FW; j++)
         if (idx == SW'(j)) dbit = frame[j];
   end

   always_comb begin
      unique case (state)
         PS_BLANK:              ctl = '0;
         PS_STEP, PS_POST: begin
            if (step == SW'(0))      ctl = 4'b0000;
            else if (step == SW'(1)) ctl = 4'b0001;
            else                     ctl = {step[0], dbit, CTL_LOW_BITS};
         end
         PS_RESTORE, PS_SETTLE: ctl = keep;
         PS_FINAL:              ctl = sel;
         default:               ctl = hold;
      endcase
   end
endmodule

// File: rtl/clkprog_seq.sv
module clkprog_seq
   import clkprog_pkg::*;
#(
   parameter int ADDR_W     = 5,
   parameter int WORD_W     = 13,
   parameter int STROBE_DLY = 3250,
   parameter int BLANK_DLY  = 1875000,
   parameter int POST_DLY   = 125000,
   parameter int SETTLE_DLY = 6250000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic [3:0]        keep_i,
   output logic [3:0]        ctl_o,
   output logic              strobe_o,
   output logic              blank_o,
   output logic              done_o
);
   localparam int FW    = HDR_W + ADDR_W + WORD_W;
   localparam int NSTEP = 2 + 2 * FW;
   localparam int SW    = $clog2(NSTEP);
   localparam int MAXA  = (STROBE_DLY > BLANK_DLY) ? STROBE_DLY : BLANK_DLY;
   localparam int MAXB  = (POST_DLY > SETTLE_DLY) ? POST_DLY : SETTLE_DLY;
   localparam int MAXD  = (MAXA > MAXB) ? MAXA : MAXB;
   localparam int CW    = $clog2(MAXD + 1);

   generate
      if (ADDR_W < CTL_W)   $error("ADDR_W must cover the final select nibble");
      if (WORD_W < 1)       $error("WORD_W must be positive");
      if (STROBE_DLY < 1)   $error("STROBE_DLY must be at least 1");
      if (BLANK_DLY < 1)    $error("BLANK_DLY must be at least 1");
      if (POST_DLY < 1)     $error("POST_DLY must be at least 1");
      if (SETTLE_DLY < 1)   $error("SETTLE_DLY must be at least 1");
   endgenerate

   ps_state_t        state_q;
   logic [SW-1:0]    step_q;
   logic [FW-1:0]    frame_q;
   logic [CTL_W-1:0] keep_q, sel_q, hold_q;
   logic [CW-1:0]    limit;
   logic             run, hit;

   always_comb begin
      run   = 1'b1;
      limit = '0;
      unique case (state_q)
         PS_BLANK:  limit = CW'(BLANK_DLY - 1);
         PS_STEP:   limit = CW'(STROBE_DLY);
         PS_POST:   limit = CW'(POST_DLY - 1);
         PS_SETTLE: limit = CW'(SETTLE_DLY - 1);
         default:   run   = 1'b0;
      endcase
   end

   clkprog_timer #(.CW(CW)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(run), .limit(limit), .hit(hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= PS_IDLE;
         step_q  <= '0;
         frame_q <= '0;
         keep_q  <= '0;
         sel_q   <= '0;
         hold_q  <= '0;
      end else begin
         unique case (state_q)
            PS_IDLE: if (start_i) begin
               frame_q <= {word_i, addr_i, HDR_BITS};
               keep_q  <= keep_i;
               sel_q   <= addr_i[CTL_W-1:0];
               state_q <= PS_BLANK;
            end
            PS_BLANK: if (hit) begin
               step_q  <= '0;
               state_q <= PS_STEP;
            end
            PS_STEP: if (hit) begin
               if (step_q == SW'(NSTEP - 1)) state_q <= PS_POST;
               else                          step_q  <= step_q + 1'b1;
            end
            PS_POST:    if (hit) state_q <= PS_RESTORE;
            PS_RESTORE: state_q <= PS_SETTLE;
            PS_SETTLE:  if (hit) state_q <= PS_FINAL;
            PS_FINAL: begin
               hold_q  <= sel_q;
               state_q <= PS_DONE;
            end
            default:    state_q <= PS_IDLE;
         endcase
      end
   end

   clkprog_ctlmux #(.FW(FW), .SW(SW)) u_ctl (
      .state(state_q), .step(step_q), .frame(frame_q),
      .keep(keep_q), .sel(sel_q), .hold(hold_q), .ctl(ctl_o)
   );

   assign strobe_o = (state_q == PS_STEP && hit) ||
                     state_q == PS_RESTORE || state_q == PS_FINAL;
   assign blank_o  = state_q == PS_BLANK || state_q == PS_STEP ||
                     state_q == PS_POST;
   assign done_o   = state_q == PS_DONE;

   // R4
   strobe_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      strobe_o |=> !strobe_o);
   // R4
   ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_o && blank_o) |-> $stable(ctl_o));
   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R8
   done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(strobe_o));
   // R10
   blank_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(blank_o) |-> $past(start_i));
   // R6
   restore_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(blank_o) |-> strobe_o);
endmodule

// File: tb/clkprog_seq_test.sv
module clkprog_seq_test;
   localparam int S = 2, B = 4, P = 3, Q = 5;
   localparam int AW = 5, WW = 13;
   localparam int FW = 3 + AW + WW;
   localparam int NSTEP = 2 + 2 * FW;
   localparam int NEV = NSTEP + 2;
   localparam int NVEC = 4;
   // vector: [21:17] addr, [16:4] word, [3:0] keep
   localparam logic [21:0] VEC [NVEC] = '{
      {5'h00, 13'h0000, 4'h0},
      {5'h1F, 13'h1FFF, 4'hF},
      {5'h15, 13'h0AAA, 4'h6},
      {5'h0B, 13'h1234, 4'h9}
   };

   logic clk = 0, rst_n = 0, start = 0;
   logic [AW-1:0] addr = '0;
   logic [WW-1:0] word = '0;
   logic [3:0] keep = '0;
   logic [3:0] ctl;
   logic strobe, blank, done;

   int total = 0, fails = 0;
   int cyc, nev, done_cyc, done_cnt;
   bit mon_on = 0;
   logic [3:0] ev_ctl [64], ev_prev [64];
   logic ev_bl [64];
   int ev_cyc [64];
   logic [3:0] prev_ctl, first_ctl;
   logic first_bl, first_stb;

   clkprog_seq #(.ADDR_W(AW), .WORD_W(WW), .STROBE_DLY(S), .BLANK_DLY(B),
                 .POST_DLY(P), .SETTLE_DLY(Q)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr),
      .word_i(word), .keep_i(keep), .ctl_o(ctl), .strobe_o(strobe),
      .blank_o(blank), .done_o(done));

   always #4 clk = ~clk;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   always @(negedge clk) if (mon_on) begin
      cyc++;
      if (cyc == 1) begin first_ctl = ctl; first_bl = blank; first_stb = strobe; end
      if (strobe && nev < 64) begin
         ev_ctl[nev] = ctl; ev_prev[nev] = prev_ctl;
         ev_bl[nev] = blank; ev_cyc[nev] = cyc; nev++;
      end
      if (done) begin done_cnt++; if (done_cyc == 0) done_cyc = cyc; end
      prev_ctl = ctl;
   end

   function automatic logic [3:0] exp_ctl(int k, logic [FW-1:0] fr,
                                          logic [3:0] kp, logic [AW-1:0] ad);
      if (k == 0) return 4'h0;
      if (k == 1) return 4'h1;
      if (k < NSTEP) return {1'(k % 2), fr[(k - 2) / 2], 2'b01};
      if (k == NSTEP) return kp;
      return ad[3:0];
   endfunction

   function automatic int exp_cyc(int k);
      int tr = B + NSTEP * (S + 1) + P + 1;
      if (k < NSTEP) return B + k * (S + 1) + S + 1;
      if (k == NSTEP) return tr;
      return tr + Q + 1;
   endfunction

   task automatic run_frame(input logic [21:0] v, input bit inject);
      logic [FW-1:0] fr;
      int t;
      fr = {v[16:4], v[21:17], 3'b001};
      @(negedge clk);
      addr = v[21:17]; word = v[16:4]; keep = v[3:0]; start = 1;
      @(posedge clk);
      cyc = 0; nev = 0; done_cyc = 0; done_cnt = 0; prev_ctl = ctl; mon_on = 1;
      @(negedge clk);
      start = 0; addr = ~addr; word = ~word; keep = ~keep;
      t = 0;
      while (done_cyc == 0 && t < 2000) begin
         @(negedge clk); t++;
         if (inject && t == 20) start = 1;   // R9 busy start
         if (inject && t == 21) start = 0;
      end
      repeat (3) @(negedge clk);
      mon_on = 0;
      #1;
      chk(first_bl && first_ctl == 0 && !first_stb, "R2", "blank/ctl after start",
          {first_bl, first_ctl}, 16);
      chk(nev == NEV, inject ? "R9" : "R4", "strobe count", nev, NEV);
      for (int k = 0; k < NEV && k < nev; k++) begin
         logic [3:0] e = exp_ctl(k, fr, v[3:0], v[21:17]);
         string rq = (k < 2) ? "R3" : (k < NSTEP) ? "R5" : (k == NSTEP) ? "R6" : "R7";
         chk(ev_ctl[k] == e, rq, $sformatf("ctl at write %0d", k), ev_ctl[k], e);
         chk(ev_cyc[k] == exp_cyc(k), "R4", $sformatf("cycle of write %0d", k),
             ev_cyc[k], exp_cyc(k));
         if (k < NSTEP)
            chk(ev_prev[k] == ev_ctl[k], "R4", "ctl held before strobe",
                ev_prev[k], ev_ctl[k]);
         chk(ev_bl[k] == (k < NSTEP), "R10", $sformatf("blank at write %0d", k),
             ev_bl[k], k < NSTEP);
      end
      chk(done_cyc == exp_cyc(NSTEP + 1) + 1, "R8", "done cycle", done_cyc,
          exp_cyc(NSTEP + 1) + 1);
      chk(done_cnt == 1, "R8", "done width", done_cnt, 1);
      chk(ctl == v[20:17] && !blank && !strobe, "R7", "idle ctl holds select",
          ctl, v[20:17]);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++; total++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(ctl == 0 && !strobe && !blank && !done, "R1", "reset outputs",
          {ctl, strobe, blank, done}, 0);
      rst_n = 1;
      repeat (2) @(negedge clk);
      chk(ctl == 0 && !strobe && !blank && !done, "R1", "idle after reset",
          {ctl, strobe, blank, done}, 0);
      for (int i = 0; i < NVEC; i++) run_frame(VEC[i], 1'b0);
      // R9: start during a running frame must not disturb it
      run_frame({5'h19, 13'h0F0F, 4'h3}, 1'b1);
      // R2: back-to-back frame right after done
      run_frame({5'h02, 13'h1001, 4'hC}, 1'b0);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule